// File: doc/BRIEF.md
# E1 Receive Signaling Highway Formatter

This block produces a serial signaling stream at the 2.048 Mbit/s highway rate. The stream runs beside the receive data highway and matches it bit for bit. The frame has 32 slots of 8 bits each, and a frame sync pulse together with a programmable slot offset positions a bit counter. Each ordinary slot carries a 4-bit signaling code in its second half, taken from a per-channel store. The first half of an ordinary slot is held at a configured level. Slot 0 repeats the received alignment word. Slot 16 carries the multiframe pattern, made of four zeros followed by spare bits and the remote multiframe alarm bit.

A freeze controller protects the store. Loss of signal, a receive slip or loss of multiframe alignment freezes the store, and no new codes are written while it is frozen. The freeze lifts only after a complete multiframe has been seen. After loss of alignment, a resynchronization event must also come first, and that event raises a one-cycle interrupt. A configuration bit can disable automatic freezing. Another configuration bit forces all ones on both serial outputs.

Top module: `e1_rx_sig_formatter`

## Requirements
- R1: A cycle with `frame_sync` high carries bit 1 of slot `ts_offset`. The position then advances by one bit per cycle and wraps from slot 31 bit 8 to slot 0 bit 1. Each serial output shows the bit for a cycle one clock later.
- R2: In slots 1–15 and 17–31, bits 5 to 8 output the stored code of that slot's channel, most significant code bit (A) first.
- R3: In slots 1–15 and 17–31, bits 1 to 4 equal `cfg_fill_hi`.
- R4: In slot 16, bits 1 to 8 are 0,0,0,0,`ts16_spare[0]`,`ts16_alarm`,`ts16_spare[1]`,`ts16_spare[2]`. Bits 1 to 4 are zero regardless of `cfg_fill_hi`.
- R5: In slot 0, `sig_out` copies `rx_data` of the same bit.
- R6: With `cfg_all_ones` high, both `sig_out` and `data_out` are 1 for every bit, overriding all other content.
- R7: With `cfg_all_ones` low, `data_out` is `rx_data` delayed by one clock.
- R8: With `cfg_no_auto` low, a `los` or `slip` pulse raises `freeze` at the next edge. `freeze` then clears at the edge of the second `mf_start` pulse after the event.
- R9: With `cfg_no_auto` low, an `mf_lost` pulse raises `freeze`. `mf_start` pulses are ignored until a `resync` pulse arrives. After that, two `mf_start` pulses clear `freeze`.
- R10: With `cfg_no_auto` high, `los`, `slip` and `mf_lost` do not change `freeze`.
- R11: A store write (`st_wr_en`, channel, code) takes effect only while `freeze` is low. While `freeze` is high the write is dropped.
- R12: `resync_irq` is high for exactly the clock following each cycle in which `resync` is high.
- R13: While reset is active, `freeze` is 1 (waiting for resynchronization), and `sig_out`, `data_out` and `resync_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame position reload pulse |
| ts_offset | input | 5 | Slot number carried in the sync cycle |
| rx_data | input | 1 | Receive data highway bit |
| cfg_fill_hi | input | 1 | Level of bits 1–4 in ordinary slots |
| cfg_all_ones | input | 1 | Force all ones on both outputs |
| cfg_no_auto | input | 1 | Disable automatic freeze |
| ts16_spare | input | 3 | Spare bits for slot 16 |
| ts16_alarm | input | 1 | Remote multiframe alarm bit for slot 16 |
| los | input | 1 | Loss-of-signal event |
| slip | input | 1 | Receive slip event |
| mf_lost | input | 1 | Multiframe alignment lost event |
| resync | input | 1 | Multiframe alignment regained event |
| mf_start | input | 1 | Multiframe boundary pulse |
| st_wr_en | input | 1 | Store write strobe |
| st_wr_ch | input | 5 | Store write channel |
| st_wr_abcd | input | 4 | Store write code, bit 3 = A |
| data_out | output | 1 | Retimed receive data |
| sig_out | output | 1 | Serial signaling bit |
| freeze | output | 1 | Freeze state |
| resync_irq | output | 1 | Resynchronization interrupt pulse |

## Verification
The hardest case is a store write dropped during freeze. The store cannot be read directly, so the write can only be detected in a later unfrozen frame. The bench first freezes the block with a slip and writes a new code while frozen. It then releases the freeze with two multiframe pulses and streams a whole frame, checking that the slot still shows the old code. It then repeats the write while unfrozen and confirms the new code appears. The loss-of-alignment path is driven in a similar way: multiframe pulses sent before the resync event must leave the block frozen.

// File: rtl/e1sig_pkg.sv
package e1sig_pkg;
  localparam int E1_SLOTS      = 32;
  localparam int BITS_PER_SLOT = 8;
  localparam int CODE_BITS     = 4;
  localparam int SLOT_W        = $clog2(E1_SLOTS);
  localparam int BIT_W         = $clog2(BITS_PER_SLOT);

  typedef enum logic [1:0] {
    FZ_RUN  = 2'd0,
    FZ_HUNT = 2'd1,
    FZ_SKIP = 2'd2,
    FZ_FILL = 2'd3
  } frz_state_t;
endpackage

// File: rtl/e1sig_slot_counter.sv
module e1sig_slot_counter #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  input  logic [$clog2(SLOTS)-1:0] ts_offset,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic [$clog2(BITS)-1:0]  bitpos
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(BITS);
  localparam int CW = SW + BW;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (frame_sync) cnt_d = {ts_offset, BW'(0)};
    else            cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slot   = cnt_d[CW-1:BW];
  assign bitpos = cnt_d[BW-1:0];
endmodule

// File: rtl/e1sig_freeze_ctrl.sv
module e1sig_freeze_ctrl
  import e1sig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_no_auto,
  input  logic los,
  input  logic slip,
  input  logic mf_lost,
  input  logic resync,
  input  logic mf_start,
  output logic freeze,
  output logic resync_irq
);
  frz_state_t st_q, st_d;
  logic       irq_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FZ_HUNT: if (resync)   st_d = FZ_SKIP;
      FZ_SKIP: if (mf_start) st_d = FZ_FILL;
      FZ_FILL: if (mf_start) st_d = FZ_RUN;
      default: st_d = st_q;
    endcase
    if (!cfg_no_auto) begin
      if ((los || slip) && (st_d != FZ_HUNT)) st_d = FZ_SKIP;
      if (mf_lost)                            st_d = FZ_HUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FZ_HUNT;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= resync;
    end
  end

  assign freeze     = (st_q != FZ_RUN);
  assign resync_irq = irq_q;
endmodule

// File: rtl/e1sig_code_store.sv
module e1sig_code_store #(
  parameter int CHANNELS = 32,
  parameter int CODE_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_block,
  input  logic [$clog2(CHANNELS)-1:0] wr_ch,
  input  logic [CODE_W-1:0]           wr_code,
  input  logic [$clog2(CHANNELS)-1:0] rd_ch,
  output logic [CODE_W-1:0]           rd_code
);
  logic [CODE_W-1:0] ent_q [CHANNELS];

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ent
    logic ld;
    assign ld = wr_en && !wr_block && (wr_ch == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[g] <= '0;
      else if (ld) ent_q[g] <= wr_code;
    end
  end

  assign rd_code = ent_q[rd_ch];
endmodule

// File: rtl/e1_rx_sig_formatter.sv
module e1_rx_sig_formatter
  import e1sig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [SLOT_W-1:0] ts_offset,
  input  logic              rx_data,
  input  logic              cfg_fill_hi,
  input  logic              cfg_all_ones,
  input  logic              cfg_no_auto,
  input  logic [2:0]        ts16_spare,
  input  logic              ts16_alarm,
  input  logic              los,
  input  logic              slip,
  input  logic              mf_lost,
  input  logic              resync,
  input  logic              mf_start,
  input  logic              st_wr_en,
  input  logic [SLOT_W-1:0] st_wr_ch,
  input  logic [CODE_BITS-1:0] st_wr_abcd,
  output logic              data_out,
  output logic              sig_out,
  output logic              freeze,
  output logic              resync_irq
);
  localparam int CW = $clog2(CODE_BITS);
  localparam logic [SLOT_W-1:0] MF_SLOT = SLOT_W'(E1_SLOTS / 2);
  localparam logic [BIT_W-1:0]  HALF    = BIT_W'(BITS_PER_SLOT - CODE_BITS);

  logic [SLOT_W-1:0]    cur_slot;
  logic [BIT_W-1:0]     cur_bit;
  logic [CODE_BITS-1:0] code;
  logic [CW-1:0]        code_idx;
  logic                 frz;
  logic                 sig_d, sig_q, data_d, data_q;

  e1sig_slot_counter #(.SLOTS(E1_SLOTS), .BITS(BITS_PER_SLOT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ts_offset(ts_offset),
    .slot(cur_slot), .bitpos(cur_bit)
  );

  e1sig_freeze_ctrl u_frz (
    .clk(clk), .rst_n(rst_n), .cfg_no_auto(cfg_no_auto), .los(los), .slip(slip),
    .mf_lost(mf_lost), .resync(resync), .mf_start(mf_start),
    .freeze(frz), .resync_irq(resync_irq)
  );

  e1sig_code_store #(.CHANNELS(E1_SLOTS), .CODE_W(CODE_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr_en), .wr_block(frz),
    .wr_ch(st_wr_ch), .wr_code(st_wr_abcd), .rd_ch(cur_slot), .rd_code(code)
  );

  // first code bit (A) is the most significant one
  assign code_idx = CW'(CODE_BITS - 1) - CW'(cur_bit - HALF);

  always_comb begin
    data_d = cfg_all_ones ? 1'b1 : rx_data;
    if (cfg_all_ones) begin
      sig_d = 1'b1;
    end else if (cur_slot == '0) begin
      sig_d = rx_data;
    end else if (cur_slot == MF_SLOT) begin
      unique case (cur_bit)
        3'd4:    sig_d = ts16_spare[0];
        3'd5:    sig_d = ts16_alarm;
        3'd6:    sig_d = ts16_spare[1];
        3'd7:    sig_d = ts16_spare[2];
        default: sig_d = 1'b0;
      endcase
    end else if (cur_bit < HALF) begin
      sig_d = cfg_fill_hi;
    end else begin
      sig_d = code[code_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q  <= 1'b0;
      data_q <= 1'b0;
    end else begin
      sig_q  <= sig_d;
      data_q <= data_d;
    end
  end

  assign sig_out  = sig_q;
  assign data_out = data_q;
  assign freeze   = frz;
endmodule

// File: rtl/e1sig_fmt_checker.sv
module e1sig_fmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_all_ones,
  input logic       cfg_no_auto,
  input logic       cfg_fill_hi,
  input logic       rx_data,
  input logic       los,
  input logic       slip,
  input logic       mf_lost,
  input logic       resync,
  input logic       mf_start,
  input logic [4:0] slot,
  input logic [2:0] bitpos,
  input logic       sig_out,
  input logic       data_out,
  input logic       freeze,
  input logic       resync_irq
);
  p_all_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_all_ones |=> (sig_out && data_out));

  p_data_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_all_ones |=> (data_out == $past(rx_data)));

  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_all_ones && slot != 5'd0 && slot != 5'd16 && bitpos < 3'd4)
      |=> (sig_out == $past(cfg_fill_hi)));

  p_ts16_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_all_ones && slot == 5'd16 && bitpos < 3'd4) |=> !sig_out);

  p_ts0_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_all_ones && slot == 5'd0) |=> (sig_out == $past(rx_data)));

  p_auto_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_no_auto && (los || slip)) |=> freeze);

  p_lost_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_no_auto && mf_lost) |=> freeze);

  p_release_on_mf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !mf_start) |=> freeze);

  p_no_auto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_no_auto && !freeze && !mf_start) |=> !freeze);

  p_irq_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> resync_irq);

  p_irq_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !resync |=> !resync_irq);
endmodule

bind e1_rx_sig_formatter e1sig_fmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_all_ones(cfg_all_ones), .cfg_no_auto(cfg_no_auto),
  .cfg_fill_hi(cfg_fill_hi), .rx_data(rx_data), .los(los), .slip(slip),
  .mf_lost(mf_lost), .resync(resync), .mf_start(mf_start),
  .slot(cur_slot), .bitpos(cur_bit), .sig_out(sig_out), .data_out(data_out),
  .freeze(freeze), .resync_irq(resync_irq)
);

// File: tb/tb_e1_rx_sig_formatter.sv
module tb_e1_rx_sig_formatter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_sync, rx_data, cfg_fill_hi, cfg_all_ones, cfg_no_auto;
  logic [4:0] ts_offset;
  logic [2:0] ts16_spare;
  logic       ts16_alarm, los, slip, mf_lost, resync, mf_start, st_wr_en;
  logic [4:0] st_wr_ch;
  logic [3:0] st_wr_abcd;
  logic       data_out, sig_out, freeze, resync_irq;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_store [32];

  // {offset[18:14], fill[13], all_ones[12], spare[11:9], alarm[8], pattern[7:0]}
  localparam logic [18:0] VEC [6] = '{
    {5'd0,  1'b0, 1'b0, 3'b101, 1'b0, 8'hA5},
    {5'd0,  1'b1, 1'b0, 3'b010, 1'b1, 8'h3C},
    {5'd7,  1'b1, 1'b0, 3'b111, 1'b1, 8'h0F},
    {5'd31, 1'b0, 1'b0, 3'b000, 1'b1, 8'hC3},
    {5'd16, 1'b1, 1'b1, 3'b011, 1'b0, 8'h00},
    {5'd3,  1'b0, 1'b0, 3'b110, 1'b0, 8'hFF}
  };

  always #5 clk = ~clk;

  e1_rx_sig_formatter dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ts_offset(ts_offset),
    .rx_data(rx_data), .cfg_fill_hi(cfg_fill_hi), .cfg_all_ones(cfg_all_ones),
    .cfg_no_auto(cfg_no_auto), .ts16_spare(ts16_spare), .ts16_alarm(ts16_alarm),
    .los(los), .slip(slip), .mf_lost(mf_lost), .resync(resync), .mf_start(mf_start),
    .st_wr_en(st_wr_en), .st_wr_ch(st_wr_ch), .st_wr_abcd(st_wr_abcd),
    .data_out(data_out), .sig_out(sig_out), .freeze(freeze), .resync_irq(resync_irq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic release_freeze();
    resync = 1'b1;
    tick();
    resync = 1'b0;
    check("R12", "irq after resync", resync_irq, 1'b1);
    check("R9", "frozen after resync", freeze, 1'b1);
    tick();
    check("R12", "irq one cycle only", resync_irq, 1'b0);
    mf_start = 1'b1;
    tick();
    check("R9", "frozen after first boundary", freeze, 1'b1);
    tick();
    mf_start = 1'b0;
    check("R9", "released after second boundary", freeze, 1'b0);
  endtask

  task automatic run_frame(input logic [18:0] v);
    int   off;
    logic fill, all1, al, rx, e;
    logic [2:0] sp;
    logic [7:0] pat;
    string req;
    off = int'(v[18:14]); fill = v[13]; all1 = v[12]; sp = v[11:9]; al = v[8]; pat = v[7:0];
    cfg_fill_hi = fill; cfg_all_ones = all1; ts16_spare = sp; ts16_alarm = al;
    for (int i = 0; i < 256; i++) begin
      int pos, s, b;
      pos = (off * 8 + i) % 256;
      s = pos / 8; b = pos % 8;
      rx = pat[(i * 3) % 8] ^ (i[4]);
      frame_sync = (i == 0);
      rx_data = rx;
      tick();
      if (all1) begin e = 1'b1; req = "R6"; end
      else if (s == 0) begin e = rx; req = "R5"; end
      else if (s == 16) begin
        req = "R4";
        case (b)
          4: e = sp[0];
          5: e = al;
          6: e = sp[1];
          7: e = sp[2];
          default: e = 1'b0;
        endcase
      end
      else if (b < 4) begin e = fill; req = "R3"; end
      else begin e = exp_store[s][3 - (b - 4)]; req = "R2"; end
      if (i == 0) check("R1", $sformatf("sync bit offset %0d", off), sig_out, e);
      check(req, $sformatf("sig slot %0d bit %0d", s, b + 1), sig_out, e);
      check(all1 ? "R6" : "R7", $sformatf("data slot %0d bit %0d", s, b + 1),
            data_out, all1 ? 1'b1 : rx);
    end
    frame_sync = 1'b0;
    cfg_all_ones = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_sync = 0; ts_offset = 0; rx_data = 0; cfg_fill_hi = 0; cfg_all_ones = 0;
    cfg_no_auto = 0; ts16_spare = 0; ts16_alarm = 0; los = 0; slip = 0; mf_lost = 0;
    resync = 0; mf_start = 0; st_wr_en = 0; st_wr_ch = 0; st_wr_abcd = 0;
    #23;
    check("R13", "reset freeze", freeze, 1'b1);
    check("R13", "reset sig_out", sig_out, 1'b0);
    check("R13", "reset data_out", data_out, 1'b0);
    check("R13", "reset irq", resync_irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    // writes while frozen after reset are dropped (R11)
    st_wr_en = 1'b1; st_wr_ch = 5'd9; st_wr_abcd = 4'hF;
    tick();
    st_wr_en = 1'b0;
    for (int c = 0; c < 32; c++) exp_store[c] = 4'h0;

    release_freeze();

    for (int c = 0; c < 32; c++) begin
      st_wr_en = 1'b1; st_wr_ch = 5'(c); st_wr_abcd = 4'(c) ^ 4'hA;
      exp_store[c] = 4'(c) ^ 4'hA;
      tick();
    end
    st_wr_en = 1'b0;

    for (int k = 0; k < 6; k++) begin
      ts_offset = VEC[k][18:14];
      run_frame(VEC[k]);
    end

    // R8 slip freeze, R11 write while frozen dropped
    slip = 1'b1;
    tick();
    slip = 1'b0;
    check("R8", "freeze after slip", freeze, 1'b1);
    st_wr_en = 1'b1; st_wr_ch = 5'd5; st_wr_abcd = ~exp_store[5];
    tick();
    st_wr_en = 1'b0;
    mf_start = 1'b1;
    tick();
    mf_start = 1'b0;
    check("R8", "still frozen after one boundary", freeze, 1'b1);
    tick();
    mf_start = 1'b1;
    tick();
    mf_start = 1'b0;
    check("R8", "released after second boundary", freeze, 1'b0);
    ts_offset = 5'd0;
    run_frame({5'd0, 1'b0, 1'b0, 3'b000, 1'b0, 8'h5A});  // R11 old code kept
    st_wr_en = 1'b1; st_wr_ch = 5'd5; st_wr_abcd = ~exp_store[5];
    exp_store[5] = ~exp_store[5];
    tick();
    st_wr_en = 1'b0;
    run_frame({5'd0, 1'b1, 1'b0, 3'b001, 1'b1, 8'h96});  // R11 new code taken

    // R8 loss of signal
    los = 1'b1;
    tick();
    los = 1'b0;
    check("R8", "freeze after los", freeze, 1'b1);
    mf_start = 1'b1;
    tick(); tick();
    mf_start = 1'b0;
    check("R8", "released after los", freeze, 1'b0);

    // R9 alignment loss needs resync first
    mf_lost = 1'b1;
    tick();
    mf_lost = 1'b0;
    check("R9", "freeze after mf_lost", freeze, 1'b1);
    mf_start = 1'b1;
    tick(); tick(); tick();
    mf_start = 1'b0;
    check("R9", "boundaries ignored before resync", freeze, 1'b1);
    slip = 1'b1;
    tick();
    slip = 1'b0;
    check("R9", "slip keeps resync wait", freeze, 1'b1);
    mf_start = 1'b1;
    tick(); tick();
    mf_start = 1'b0;
    check("R9", "still waiting for resync", freeze, 1'b1);
    release_freeze();

    // R10 automatic freeze disabled
    cfg_no_auto = 1'b1;
    los = 1'b1; tick(); los = 1'b0;
    check("R10", "los ignored", freeze, 1'b0);
    slip = 1'b1; tick(); slip = 1'b0;
    check("R10", "slip ignored", freeze, 1'b0);
    mf_lost = 1'b1; tick(); mf_lost = 1'b0;
    check("R10", "mf_lost ignored", freeze, 1'b0);
    cfg_no_auto = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule